// File: doc/BRIEF.md
# Parallel-In Serial-Out Multi-Trunk Time Switch

This block switches time slots between several multiplexed trunks. N input trunks and N output trunks each carry M slots per frame. Every slot lasts N+1 clock cycles, called subslots. In the first subslot the samples of all input trunks are written at once. Each sample goes into the storage bank that belongs to its trunk, at the word numbered by the current slot.

In each of the following N subslots, one entry of a connection table is fetched. The entry names a source bank and a word in that bank. The sample stored there is routed to one output trunk, in output order. The N routed samples are collected and released together on all output trunks once the slot ends.

The connection table has N×M entries. The entry for output o in slot i sits at address i·N+o. A simple write port loads the table. The `OVERLAP` parameter selects a variant in which the table fetch is registered one subslot ahead of the bank read. In that variant the table pointer stalls in the last subslot instead of the first, and the outputs are unchanged.

Top module: `pso_time_switch`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `sub_idx` and `slot_idx` read 0, `out_valid` is 0, and `out_samples` and `out_slot` are all zero.
- R2: `sub_idx` counts 0 to N and back to 0, one step per clock. `slot_idx` advances on each wrap of `sub_idx` and counts 0 to M-1 cyclically, so a frame lasts (N+1)·M cycles.
- R3: On the clock edge that ends subslot 0 of slot i, lane n of `in_samples` (bits n·W upward) is stored in bank n at word i, for every n at once.
- R4: A table entry holds the bank number in its upper ceil(log2 N) bits and the word number in its lower ceil(log2 M) bits. The entry used for output lane o in slot i is at address i·N+o.
- R5: Output lane o for slot i carries the value most recently stored in the bank and word named by its entry. If that word is i, this is the sample captured in subslot 0 of the same slot.
- R6: All N output lanes change together, only on the edge that ends subslot N. `out_valid` is high for exactly the following cycle, with `out_slot` giving the slot they belong to. Otherwise `out_samples` holds its value.
- R7: Any number of outputs may name the same bank and word in the same slot, and each of them receives that sample.
- R8: With `OVERLAP`=1 the outputs, their timing and `out_slot` are identical to `OVERLAP`=0. The table pointer then equals slot·N at subslot 0, instead of at subslot 1.
- R9: When `cm_we` is high, `cm_wdata` is written to table address `cm_addr` on the clock edge, whether or not reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subslot clock |
| rst_n | input | 1 | Synchronous active-low reset of sequencing and outputs |
| in_samples | input | N·W | One sample per input trunk, lane n at bits n·W upward |
| cm_we | input | 1 | Connection table write strobe |
| cm_addr | input | ceil(log2(N·M)) | Connection table write address |
| cm_wdata | input | ceil(log2 N)+ceil(log2 M) | Table entry: bank in the upper field, word in the lower field |
| sub_idx | output | ceil(log2(N+1)) | Current subslot |
| slot_idx | output | ceil(log2 M) | Current slot |
| out_samples | output | N·W | One sample per output trunk, lane o at bits o·W upward |
| out_valid | output | 1 | One-cycle strobe marking new output samples |
| out_slot | output | ceil(log2 M) | Slot to which `out_samples` belongs |

## Verification
The bench targets the three cases where a word is read relative to its write:
- an entry that names the current slot's word, which a design with the write and the read misordered would return one frame stale;
- words ahead of the slot, which must still hold the previous frame's data;
- words behind the slot, which must hold this frame's data.

Broadcast tables catch a router that lets only one output claim a source. Running a registered-fetch instance beside the plain one exposes a pointer stall placed in the wrong subslot: such a design shifts every output lane by one table entry. Checks on the strobe and the slot tag catch outputs that trickle out lane by lane instead of together.

// File: rtl/pso_time_switch.sv
module pso_time_switch #(
  parameter int N_TRUNKS = 4,
  parameter int SLOTS    = 8,
  parameter int SAMPLE_W = 8,
  parameter bit OVERLAP  = 1'b0
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic [N_TRUNKS*SAMPLE_W-1:0]                 in_samples,
  input  logic                                         cm_we,
  input  logic [$clog2(N_TRUNKS*SLOTS)-1:0]            cm_addr,
  input  logic [$clog2(N_TRUNKS)+$clog2(SLOTS)-1:0]    cm_wdata,
  output logic [$clog2(N_TRUNKS+1)-1:0]                sub_idx,
  output logic [$clog2(SLOTS)-1:0]                     slot_idx,
  output logic [N_TRUNKS*SAMPLE_W-1:0]                 out_samples,
  output logic                                         out_valid,
  output logic [$clog2(SLOTS)-1:0]                     out_slot
);
  localparam int MOD_W    = $clog2(N_TRUNKS);
  localparam int WORD_W   = $clog2(SLOTS);
  localparam int CW       = MOD_W + WORD_W;
  localparam int CM_DEPTH = N_TRUNKS * SLOTS;
  localparam int CA_W     = $clog2(CM_DEPTH);
  localparam int SUB_W    = $clog2(N_TRUNKS + 1);
  localparam int DW       = N_TRUNKS * SAMPLE_W;
  localparam int STAGE_W  = (N_TRUNKS - 1) * SAMPLE_W;

  logic [SUB_W-1:0]  sub;
  logic [WORD_W-1:0] slot;
  logic              last_sub;

  assign last_sub = (sub == SUB_W'(N_TRUNKS));
  assign sub_idx  = sub;
  assign slot_idx = slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub  <= '0;
      slot <= '0;
    end else if (last_sub) begin
      sub  <= '0;
      slot <= (slot == WORD_W'(SLOTS - 1)) ? '0 : slot + 1'b1;
    end else begin
      sub <= sub + 1'b1;
    end
  end

  logic [CW-1:0]   cmem [CM_DEPTH];
  logic [CA_W-1:0] cm_ptr;
  logic            cm_step;
  logic [CW-1:0]   cm_word;

  always_ff @(posedge clk) begin
    if (cm_we) cmem[cm_addr] <= cm_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cm_ptr <= '0;
    else if (cm_step) cm_ptr <= (cm_ptr == CA_W'(CM_DEPTH - 1)) ? '0 : cm_ptr + 1'b1;
  end

  generate
    if (OVERLAP) begin : g_ovl
      logic [CW-1:0] cm_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       cm_q <= '0;
        else if (cm_step) cm_q <= cmem[cm_ptr];
      end
      assign cm_step = !last_sub;
      assign cm_word = cm_q;
    end else begin : g_seq
      assign cm_step = (sub != '0);
      assign cm_word = cmem[cm_ptr];
    end
  endgenerate

  logic [MOD_W-1:0]    sel_mod;
  logic [WORD_W-1:0]   sel_word;
  logic [DW-1:0]       mod_rd;
  logic [SAMPLE_W-1:0] dm_rd;

  assign sel_mod  = cm_word[CW-1:WORD_W];
  assign sel_word = cm_word[WORD_W-1:0];

  for (genvar g = 0; g < N_TRUNKS; g++) begin : g_mod
    logic [SAMPLE_W-1:0] words [SLOTS];
    always_ff @(posedge clk) begin
      if (sub == '0) words[slot] <= in_samples[g*SAMPLE_W +: SAMPLE_W];
    end
    assign mod_rd[g*SAMPLE_W +: SAMPLE_W] = words[sel_word];
  end

  assign dm_rd = mod_rd[int'(sel_mod)*SAMPLE_W +: SAMPLE_W];

  logic [STAGE_W-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n)
      stage <= '0;
    else if (sub != '0 && !last_sub)
      stage[(int'(sub) - 1)*SAMPLE_W +: SAMPLE_W] <= dm_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_samples <= '0;
      out_valid   <= 1'b0;
      out_slot    <= '0;
    end else begin
      out_valid <= last_sub;
      if (last_sub) begin
        out_samples <= {dm_rd, stage};
        out_slot    <= slot;
      end
    end
  end
endmodule

module pso_time_switch_chk #(
  parameter int N_TRUNKS = 4,
  parameter int SLOTS    = 8,
  parameter int SAMPLE_W = 8,
  parameter bit OVERLAP  = 1'b0,
  parameter int SUB_W    = $clog2(N_TRUNKS + 1),
  parameter int WORD_W   = $clog2(SLOTS),
  parameter int CA_W     = $clog2(N_TRUNKS * SLOTS)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [SUB_W-1:0]             sub,
  input logic [WORD_W-1:0]            slot,
  input logic [CA_W-1:0]              cm_ptr,
  input logic                         out_valid,
  input logic [N_TRUNKS*SAMPLE_W-1:0] out_samples
);
  assert_sub_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sub == SUB_W'(N_TRUNKS) |=> sub == '0);

  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub == SUB_W'(N_TRUNKS) && slot == WORD_W'(SLOTS - 1)) |=> slot == '0);

  assert_strobe_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sub == '0);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_samples));

  generate
    if (OVERLAP) begin : g_ovl_chk
      assert_ptr_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sub == '0 |-> int'(cm_ptr) == int'(slot) * N_TRUNKS);
    end else begin : g_seq_chk
      assert_ptr_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sub == SUB_W'(1) |-> int'(cm_ptr) == int'(slot) * N_TRUNKS);
    end
  endgenerate
endmodule

bind pso_time_switch pso_time_switch_chk #(
  .N_TRUNKS(N_TRUNKS), .SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W), .OVERLAP(OVERLAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sub(sub), .slot(slot), .cm_ptr(cm_ptr),
  .out_valid(out_valid), .out_samples(out_samples)
);

// File: tb/pso_time_switch_test.sv
module pso_time_switch_test;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 4;
  localparam int M      = 8;
  localparam int SW     = 8;
  localparam int MOD_W  = 2;
  localparam int WORD_W = 3;
  localparam int CW     = MOD_W + WORD_W;
  localparam int CA_W   = 5;
  localparam int SUB_W  = 3;
  localparam int DW     = N * SW;
  localparam int SLOT_CYC = N + 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [DW-1:0]     in_samples = '0;
  logic              cm_we;
  logic [CA_W-1:0]   cm_addr;
  logic [CW-1:0]     cm_wdata;
  logic [SUB_W-1:0]  sub_idx, ovl_sub;
  logic [WORD_W-1:0] slot_idx, ovl_slot;
  logic [DW-1:0]     out_samples, ovl_out;
  logic              out_valid, ovl_valid;
  logic [WORD_W-1:0] out_slot, ovl_out_slot;

  always #(CLK_PERIOD/2) clk = ~clk;

  pso_time_switch #(.N_TRUNKS(N), .SLOTS(M), .SAMPLE_W(SW), .OVERLAP(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .in_samples(in_samples), .cm_we(cm_we), .cm_addr(cm_addr),
    .cm_wdata(cm_wdata), .sub_idx(sub_idx), .slot_idx(slot_idx), .out_samples(out_samples),
    .out_valid(out_valid), .out_slot(out_slot));

  pso_time_switch #(.N_TRUNKS(N), .SLOTS(M), .SAMPLE_W(SW), .OVERLAP(1'b1)) uut_ovl (
    .clk(clk), .rst_n(rst_n), .in_samples(in_samples), .cm_we(cm_we), .cm_addr(cm_addr),
    .cm_wdata(cm_wdata), .sub_idx(ovl_sub), .slot_idx(ovl_slot), .out_samples(ovl_out),
    .out_valid(ovl_valid), .out_slot(ovl_out_slot));

  typedef struct {
    bit                chk;
    logic [WORD_W-1:0] slot;
    logic [DW-1:0]     data;
  } exp_t;

  exp_t          q[$];
  logic [SW-1:0] mdl_dm [N][M];
  logic [CW-1:0] mdl_cm [N*M];
  int            frame = 0;
  int            seed  = 0;
  string         tag   = "R3/R5 straight-through";
  int            checks = 0;
  int            fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [SW-1:0] pat(int fr, int sl, int tr, int sd);
    return SW'((fr*37 + sl*11 + tr*53 + sd*71 + 1) & 255);
  endfunction

  // R4: bank number in the upper field, word number in the lower field
  function automatic logic [CW-1:0] cfg_word(int cfg, int sl, int o);
    int md, wd;
    case (cfg)
      0:       begin md = o;         wd = sl;               end
      1:       begin md = N - 1 - o; wd = (sl + 3 + o) % M; end
      default: begin md = 2;         wd = 5;                end
    endcase
    return {MOD_W'(md), WORD_W'(wd)};
  endfunction

  // R9: table loaded while reset is held
  task automatic load_cm(int cfg);
    for (int sl = 0; sl < M; sl++) begin
      for (int o = 0; o < N; o++) begin
        @(negedge clk);
        cm_we    = 1'b1;
        cm_addr  = CA_W'(sl*N + o);
        cm_wdata = cfg_word(cfg, sl, o);
        mdl_cm[sl*N + o] = cm_wdata;
      end
    end
    @(negedge clk);
    cm_we = 1'b0;
  endtask

  initial begin : driver
    forever begin
      @(negedge clk);
      if (sub_idx == '0) begin
        exp_t          e;
        logic [CW-1:0] w;
        for (int n = 0; n < N; n++) begin
          in_samples[n*SW +: SW] = pat(frame, int'(slot_idx), n, seed);
          mdl_dm[n][slot_idx]    = in_samples[n*SW +: SW];
        end
        if (rst_n) begin
          for (int o = 0; o < N; o++) begin
            w = mdl_cm[int'(slot_idx)*N + o];
            e.data[o*SW +: SW] = mdl_dm[w[CW-1:WORD_W]][w[WORD_W-1:0]];
          end
          e.chk  = (frame >= 1);
          e.slot = slot_idx;
          q.push_back(e);
          if (slot_idx == WORD_W'(M - 1)) frame++;
        end
      end
    end
  end

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R6 strobe with no slot pending", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.chk) begin
            chk(out_slot == e.slot, "R6 output slot tag", out_slot, e.slot);
            for (int o = 0; o < N; o++)
              chk(out_samples[o*SW +: SW] == e.data[o*SW +: SW],
                  $sformatf("%s lane %0d", tag, o), out_samples[o*SW +: SW], e.data[o*SW +: SW]);
            chk(ovl_valid && ovl_out_slot == e.slot, "R8 overlapped strobe and tag",
                {ovl_valid, ovl_out_slot}, {1'b1, e.slot});
            chk(ovl_out == e.data, "R8 overlapped variant data", ovl_out, e.data);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD*50000);
    chk(1'b0, "R2 watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin : main
    rst_n    = 1'b0;
    cm_we    = 1'b0;
    cm_addr  = '0;
    cm_wdata = '0;
    for (int cfg = 0; cfg < 3; cfg++) begin
      @(negedge clk);
      rst_n = 1'b0;
      q.delete();
      frame = 0;
      seed  = cfg;
      tag   = (cfg == 0) ? "R3/R5 straight-through" :
              (cfg == 1) ? "R4/R5 interchange" : "R7 broadcast";
      load_cm(cfg);
      if (cfg == 0) begin
        repeat (2) @(negedge clk);
        chk(sub_idx == '0 && slot_idx == '0, "R1 counters in reset", {sub_idx, slot_idx}, 0);
        chk(out_valid == 1'b0, "R1 strobe in reset", out_valid, 0);
        chk(out_samples == '0, "R1 outputs in reset", out_samples, 0);
        chk(out_slot == '0, "R1 slot tag in reset", out_slot, 0);
      end
      @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      if (cfg == 0) begin
        chk(sub_idx == '0 && slot_idx == '0 && !out_valid, "R1 first cycle after reset",
            {out_valid, sub_idx, slot_idx}, 0);
      end
      repeat (SLOT_CYC*M*4) @(negedge clk);
      if (cfg == 0) begin
        int cyc = 0;
        int smax = 0;
        while (!(sub_idx == '0 && slot_idx == '0)) @(negedge clk);
        do begin
          @(negedge clk);
          cyc++;
          if (int'(sub_idx) > smax) smax = int'(sub_idx);
        end while (!(sub_idx == '0 && slot_idx == '0));
        chk(cyc == SLOT_CYC*M, "R2 frame length", cyc, SLOT_CYC*M);
        chk(smax == N, "R2 highest subslot", smax, N);
      end
    end
    chk(q.size() <= 1, "R6 slots left without strobe", q.size(), 1);
    summary();
    $finish;
  end
endmodule